// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is a write-only serial port that loads a small bank of configuration registers. A host lowers a chip-select line, clocks a 16-bit command in on a data line with a serial clock, and then raises chip-select. The command is committed to a register on that rising edge. The upper seven bits of the command select a register and the lower nine bits are the value written. The serial inputs are asynchronous to the block. They are synchronised into the system clock domain and their edges are detected there.

Every register drives its configuration bits straight out of the block. Register 0 holds the power-down controls and is also decoded into dedicated outputs. A global power-down bit in it overrides the ADC power-down bit and the per-DAC power-down bits. A mode input enables the serial port. When the mode input is low, the port ignores all serial activity, and that state stands for pin-programmed control.

Top module: `scfg_port`

## Requirements
- R1: During and after a synchronous active-high reset, register 0 reads 0x01F (everything powered down) and every other register reads 0. The outputs then read pd_adc_o=1, pd_dac_o=3'b111 and pd_ref_o=1.
- R2: The data line is sampled on each rising edge of the serial clock while chip-select is low. Bits arrive most significant first. Bits [15:9] of the command are the register address and bits [8:0] are the data.
- R3: The command is written only when chip-select rises. Until then, no register changes, even after all 16 bits have been shifted in.
- R4: A rising edge of chip-select that follows any bit count other than 16 discards the command. Counts of 15 and 17 are examples.
- R5: A command to an address at or above NUM_REGS changes no register.
- R6: While mode_sw is low, serial activity has no effect on any register.
- R7: Register 0 has bit 0 as ADC power-down, bits 3:1 as DAC 0..2 power-down, and bit 4 as global power-down. pd_ref_o equals bit 4. pd_adc_o equals bit 4 OR bit 0. pd_dac_o[i] equals bit 4 OR bit i+1.
- R8: A falling edge of chip-select restarts the bit count, so a valid frame that follows a discarded frame is written correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sw | input | 1 | 1 enables the serial port (software control) |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_csn | input | 1 | Chip-select, active low; a rising edge commits the command |
| regs_o | output | NUM_REGS*DATA_W | All registers, register i at bits [i*DATA_W +: DATA_W] |
| pd_adc_o | output | 1 | ADC power-down |
| pd_dac_o | output | NUM_DAC | Per-DAC power-down |
| pd_ref_o | output | 1 | Reference power-down |

## Verification
The bench builds the block with NUM_REGS=6 and SYNC_STAGES=3. With NUM_REGS=6, the addresses from 6 upward are unimplemented, so random commands aimed at addresses up to 9 regularly exercise the rejection of unused addresses. The three-stage synchroniser adds latency through the edge detectors, and the bench's serial timing with four system clocks per half period must still meet it. The random frames mix in wrong bit counts and disabled mode, so discarded commands fall between valid ones.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // Positions inside the power-down register.
  localparam int PD_ADC_BIT = 0;
  localparam int PD_DAC_LSB = 1;

  // Reset value of register idx: register 0 powers everything down.
  function automatic logic [31:0] reg_default(int idx, int ndac);
    logic [31:0] v;
    v = 32'd0;
    if (idx == 0) v = (32'd1 << (ndac + 2)) - 32'd1;
    return v;
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FW    = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FW + 1);

  logic [FW-1:0]    sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      cnt     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (sel_fall) begin
        cnt <= '0;
      end else if (!sel_n && sck_rise && en) begin
        sreg <= {sreg[FW-2:0], sdi};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      if (sel_rise) begin
        wr_en   <= en && (cnt == CNT_FULL);
        wr_addr <= sreg[FW-1:DATA_W];
        wr_data <= sreg[DATA_W-1:0];
        cnt     <= '0;
      end
    end
  end
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter int NUM_REGS = 8,
  parameter int NUM_DAC  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS*DATA_W-1:0]   regs
);
  import scfg_pkg::*;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit = (32'(wr_addr) < NUM_REGS);
  assign idx = IDX_W'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= DATA_W'(reg_default(i, NUM_DAC));
    end else if (wr_en && hit) begin
      mem[idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/scfg_port.sv
module scfg_port #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int NUM_REGS    = 8,
  parameter int NUM_DAC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_sw,
  input  logic                       ser_clk,
  input  logic                       ser_dat,
  input  logic                       ser_csn,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       pd_adc_o,
  output logic [NUM_DAC-1:0]         pd_dac_o,
  output logic                       pd_ref_o
);
  import scfg_pkg::*;
  localparam int GLB_BIT = PD_DAC_LSB + NUM_DAC;

  logic [3:0] raw_in, syn;
  logic       sck_q, sdi_q, csn_q, mode_q;
  logic       sck_prev, csn_prev;
  logic       sck_rise, csn_rise, csn_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] pd_word;

  assign raw_in = {mode_sw, ser_csn, ser_dat, ser_clk};

  scfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign sck_q  = syn[0];
  assign sdi_q  = syn[1];
  assign csn_q  = syn[2];
  assign mode_q = syn[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      csn_prev <= 1'b1;
    end else begin
      sck_prev <= sck_q;
      csn_prev <= csn_q;
    end
  end

  assign sck_rise = sck_q & ~sck_prev;
  assign csn_rise = csn_q & ~csn_prev;
  assign csn_fall = ~csn_q & csn_prev;

  scfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .en(mode_q), .sel_n(csn_q),
    .sel_fall(csn_fall), .sel_rise(csn_rise), .sck_rise(sck_rise), .sdi(sdi_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  scfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                 .NUM_DAC(NUM_DAC)) rf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs_o)
  );

  assign pd_word = regs_o[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_adc_o <= 1'b1;
      pd_dac_o <= '1;
      pd_ref_o <= 1'b1;
    end else begin
      pd_ref_o <= pd_word[GLB_BIT];
      pd_adc_o <= pd_word[GLB_BIT] | pd_word[PD_ADC_BIT];
      for (int i = 0; i < NUM_DAC; i++)
        pd_dac_o[i] <= pd_word[GLB_BIT] | pd_word[PD_DAC_LSB + i];
    end
  end
endmodule

// File: rtl/scfg_port_chk.sv
module scfg_port_chk #(
  parameter int DATA_W   = 9,
  parameter int NUM_REGS = 8,
  parameter int NUM_DAC  = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mode_q,
  input logic                       wr_en,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic                       pd_adc,
  input logic [NUM_DAC-1:0]         pd_dac,
  input logic                       pd_ref
);
  localparam int GLB_BIT = NUM_DAC + 1;

  logic [NUM_REGS*DATA_W-1:0] prev_regs;
  logic                       wr_en_d;
  logic [NUM_REGS-1:0]        chg;

  always_ff @(posedge clk) begin
    prev_regs <= regs;
    wr_en_d   <= rst ? 1'b0 : wr_en;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = regs[g*DATA_W +: DATA_W] != prev_regs[g*DATA_W +: DATA_W];
  end

  assert_write_needs_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (chg != '0) |-> wr_en_d);

  assert_one_reg_per_write_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));

  assert_mode_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (chg == '0));

  assert_global_override_R7: assert property (@(posedge clk) disable iff (rst)
    prev_regs[GLB_BIT] |-> (pd_ref && pd_adc && (&pd_dac)));
endmodule

bind scfg_port scfg_port_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_DAC(NUM_DAC)) chk_i (
  .clk(clk), .rst(rst), .mode_q(mode_q), .wr_en(wr_en), .regs(regs_o),
  .pd_adc(pd_adc_o), .pd_dac(pd_dac_o), .pd_ref(pd_ref_o)
);

// File: tb/scfg_port_tb_top.sv
module scfg_port_tb_top;
  localparam int ADDR_W = 7, DATA_W = 9, NUM_REGS = 6, NUM_DAC = 3, SYNC_STAGES = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_sw = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1;
  logic [NUM_REGS*DATA_W-1:0] regs_o;
  logic pd_adc_o, pd_ref_o;
  logic [NUM_DAC-1:0] pd_dac_o;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] exp_r [NUM_REGS];

  always #2 clk = ~clk;

  scfg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
              .NUM_DAC(NUM_DAC), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk(clk), .rst(rst), .mode_sw(mode_sw), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_csn(ser_csn), .regs_o(regs_o), .pd_adc_o(pd_adc_o), .pd_dac_o(pd_dac_o),
    .pd_ref_o(pd_ref_o)
  );

  function automatic logic [4:0] exp_pd(logic [DATA_W-1:0] w);
    logic g;
    g = w[4];
    return {g, g | w[3], g | w[2], g | w[1], g | w[0]};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [4:0] e;
    for (int i = 0; i < NUM_REGS; i++) begin
      checks++;
      if (regs_o[i*DATA_W +: DATA_W] !== exp_r[i]) begin
        fails++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, i,
                 regs_o[i*DATA_W +: DATA_W], exp_r[i]);
      end
    end
    e = exp_pd(exp_r[0]);
    checks++;
    if ({pd_ref_o, pd_dac_o, pd_adc_o} !== e) begin
      fails++;
      $display("FAIL %s R7 pd actual=%b expected=%b", tag,
               {pd_ref_o, pd_dac_o, pd_adc_o}, e);
    end
  endtask

  task automatic shift_bits(logic [31:0] w, int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = w[b];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
  endtask

  // Sends n bits of w framed by chip-select; updates the model when valid.
  task automatic frame(logic [31:0] w, int n, string tag);
    ser_csn = 1'b0;
    wait_clk(6);
    shift_bits(w, n);
    wait_clk(6);
    ser_csn = 1'b1;
    wait_clk(14);
    if (n == 16 && mode_sw && 32'(w[15:9]) < NUM_REGS) exp_r[w[12:9]] = w[8:0];
    check_all(tag);
  endtask

  function automatic logic [31:0] cmd(int a, int d);
    return {16'd0, 7'(a), 9'(d)};
  endfunction

  initial begin
    for (int i = 0; i < NUM_REGS; i++) exp_r[i] = (i == 0) ? 9'h01F : 9'h000;
    void'($urandom(32'd20240611));
    wait_clk(3);
    check_all("R1 during reset");
    rst = 1'b0;
    wait_clk(8);
    check_all("R1 after reset");

    // R2: address/data fields, MSB first
    frame(cmd(2, 9'h1A5), 16, "R2 write reg2");
    frame(cmd(5, 9'h0C3), 16, "R2 write reg5");

    // R7: clear global and ADC, keep DAC1 down
    frame(cmd(0, 9'h004), 16, "R7 partial pd");
    frame(cmd(0, 9'h011), 16, "R7 global override");
    frame(cmd(0, 9'h000), 16, "R7 all up");

    // R3: no change before chip-select rises
    ser_csn = 1'b0;
    wait_clk(6);
    shift_bits(cmd(3, 9'h155), 16);
    wait_clk(16);
    check_all("R3 before commit");
    ser_csn = 1'b1;
    wait_clk(14);
    exp_r[3] = 9'h155;
    check_all("R3 after commit");

    // R4: wrong counts discarded
    frame({15'd0, cmd(1, 9'h0FF)} , 15, "R4 15 bits");
    frame({cmd(1, 9'h0FF)[15:0], 1'b1}, 17, "R4 17 bits");
    // R8: count restarts after a discarded frame
    frame(cmd(1, 9'h0AA), 16, "R8 after discard");

    // R5: unimplemented addresses
    frame(cmd(6, 9'h1FF), 16, "R5 addr 6");
    frame(cmd(127, 9'h1FF), 16, "R5 addr 127");

    // R6: mode low ignores the port
    mode_sw = 1'b0;
    wait_clk(10);
    frame(cmd(4, 9'h1FF), 16, "R6 mode off");
    mode_sw = 1'b1;
    wait_clk(10);
    frame(cmd(4, 9'h033), 16, "R6 mode back on");

    // Random mix (R2 R4 R5 R6 R7)
    for (int k = 0; k < 60; k++) begin
      int a, d, n, r;
      a = int'($urandom_range(0, 9));
      d = int'($urandom_range(0, 511));
      r = int'($urandom_range(0, 9));
      n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      if (mode_sw != (r != 2)) begin
        mode_sw = (r != 2);
        wait_clk(10);
      end
      if (n == 17) frame({cmd(a, d)[15:0], 1'b0}, 17, "R4 random");
      else if (n == 15) frame(cmd(a, d) >> 1, 15, "R4 random");
      else frame(cmd(a, d), 16, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule